// File: doc/BRIEF.md
# Multi-Counter Performance Monitoring Unit

This block gives a processor core a set of event counters that software programs and reads over a small register bus. There are four slots by default. Each slot holds a control word and a 32-bit count. The control word chooses which event source the slot follows and the privilege states in which it may count. It also sets whether an overflowed count raises the performance interrupt. Event numbers are assigned separately to even-numbered and odd-numbered slots. Two shared sources, cycles and completed instructions, can be counted by any slot.

A count is treated as overflowed once its most significant bit is 1; wrap to zero plays no part. Overflow together with the slot's interrupt enable drives the interrupt line, and the same condition shows in a cause-style status word. Software discovers how many slots exist from a read-only chaining flag in each control word, and from a presence bit in a configuration status word. To stop a slot, software clears its four privilege enables. Setting them again resumes the count from its held value.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset every count and every writable control field is 0 and irq_o is low, so nothing counts until software writes a control word.
- R2: Control word layout: bit 0 permits counting while the exception-level flag is set, bit 1 in kernel state, bit 2 in supervisor state, bit 3 in user state, bit 4 is the interrupt enable, and bits 14:5 are the event selector. Bits 30:15 read 0. Bit 31 is read-only and reads 1 in every slot except the last.
- R3: cfg_word_o reads 0x00000010: bit 4 set shows that counters are present, and all other bits are 0.
- R4: Kernel state holds when ksu_i is 00 or exl_i or erl_i is 1. Supervisor state holds when ksu_i is 01 and both flags are 0. User state holds when ksu_i is 10 and both flags are 0. The bit-0 enable counts whenever exl_i is 1. ksu_i of 11 with both flags 0 matches no state.
- R5: A slot whose four privilege enables are all 0 holds its count. Setting them again resumes counting from the held value.
- R6: Selector 0 follows common_ev_i[0] and selector 1 follows common_ev_i[1] in any slot. Selector s from 2 to EV_N+1 follows even_ev_i[s-2] in even slots and odd_ev_i[s-2] in odd slots. Any other selector value counts nothing.
- R7: In each cycle where the selected event is 1 and the privilege state is enabled, the count rises by exactly one, wrapping from 0xFFFFFFFF to 0.
- R8: irq_o is 1 exactly when at least one slot has count bit 31 set and its interrupt enable (bit 4) set.
- R9: cause_word_o bit 26 mirrors the pending interrupt, and its other bits are 0.
- R10: A counter write replaces the count, and it takes precedence over an event in that cycle, so no increment is added. Writing a value with bit 31 clear removes that slot's overflow.
- R11: addr_i[0] = 0 selects the control word and addr_i[0] = 1 selects the count of slot addr_i[2:1]. A write takes effect at the next clock edge, and rdata_o follows addr_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register select: {slot, count-not-control} |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed register |
| ksu_i | input | 2 | Current privilege field of the core |
| exl_i | input | 1 | Exception-level flag of the core |
| erl_i | input | 1 | Error-level flag of the core |
| common_ev_i | input | 2 | Shared events: cycles [0], instructions [1] |
| even_ev_i | input | 8 | Event sources for even-numbered slots |
| odd_ev_i | input | 8 | Event sources for odd-numbered slots |
| irq_o | output | 1 | Performance counter interrupt request |
| cfg_word_o | output | 32 | Configuration status word, presence at bit 4 |
| cause_word_o | output | 32 | Cause status word, pending bit at 26 |

## Verification
A software write to a count and a qualifying event on that same slot can land in one clock cycle. The bench provokes this by raising the shared cycle event at the same falling edge at which it drives the counter write. It then reads the count. It passes only if the count equals the written value with no increment added, and rises by one on the next qualifying cycle. A second overlap has a count crossing into bit 31 while the interrupt enable is toggled. That case is judged from irq_o and the cause word.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
package pmu_pkg;
    // control word field positions (software-visible layout)
    localparam int CTL_EN_EXL = 0;
    localparam int CTL_EN_KRN = 1;
    localparam int CTL_EN_SUP = 2;
    localparam int CTL_EN_USR = 3;
    localparam int CTL_IE     = 4;
    localparam int CTL_SEL_LO = 5;
    localparam int SEL_W      = 10;
    localparam int CTL_RW_W   = CTL_SEL_LO + SEL_W;
    localparam int CFG_PRESENT_BIT = 4;
    localparam int CAUSE_PEND_BIT  = 26;
    // privilege field encodings
    localparam logic [1:0] KSU_KERNEL = 2'b00;
    localparam logic [1:0] KSU_SUPER  = 2'b01;
    localparam logic [1:0] KSU_USER   = 2'b10;
endpackage

// File: rtl/pmu_mode_gate.sv
`timescale 1ns/1ps
module pmu_mode_gate
    import pmu_pkg::*;
(
    input  logic [3:0] en_i,
    input  logic [1:0] ksu_i,
    input  logic       exl_i,
    input  logic       erl_i,
    output logic       allow_o
);
    logic kern;
    logic plain;

    always_comb begin
        kern    = (ksu_i == KSU_KERNEL) || exl_i || erl_i;
        plain   = !exl_i && !erl_i;
        allow_o = (en_i[CTL_EN_KRN] && kern)
               || (en_i[CTL_EN_EXL] && exl_i)
               || (en_i[CTL_EN_SUP] && plain && (ksu_i == KSU_SUPER))
               || (en_i[CTL_EN_USR] && plain && (ksu_i == KSU_USER));
    end

    // all enables cleared must stop counting in every privilege state
    always_comb begin
        if (en_i == 4'b0000) begin
            assert_off_when_masked_R5: assert (!allow_o);
        end
    end
endmodule

// File: rtl/pmu_evt_sel.sv
`timescale 1ns/1ps
module pmu_evt_sel
    import pmu_pkg::*;
#(
    parameter int EV_N = 8
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic [1:0]       common_ev_i,
    input  logic [EV_N-1:0]  class_ev_i,
    output logic             hit_o
);
    always_comb begin
        hit_o = 1'b0;
        if (sel_i == SEL_W'(0)) hit_o = common_ev_i[0];
        if (sel_i == SEL_W'(1)) hit_o = common_ev_i[1];
        for (int k = 0; k < EV_N; k++) begin
            if (sel_i == SEL_W'(k + 2)) hit_o = class_ev_i[k];
        end
    end
endmodule

// File: rtl/pmu_pair.sv
`timescale 1ns/1ps
module pmu_pair
    import pmu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int EV_N    = 8,
    parameter int IS_LAST = 0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_ctl_i,
    input  logic              wr_cnt_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [1:0]        ksu_i,
    input  logic              exl_i,
    input  logic              erl_i,
    input  logic [1:0]        common_ev_i,
    input  logic [EV_N-1:0]   class_ev_i,
    output logic [DATA_W-1:0] ctl_o,
    output logic [DATA_W-1:0] cnt_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [CTL_RW_W-1:0] ctl;
        logic [DATA_W-1:0]   cnt;
    } pair_t;

    pair_t st_d, st_q;
    logic  allow;
    logic  hit;
    logic  tick;

    pmu_mode_gate u_gate (
        .en_i    (st_q.ctl[CTL_EN_USR:CTL_EN_EXL]),
        .ksu_i   (ksu_i),
        .exl_i   (exl_i),
        .erl_i   (erl_i),
        .allow_o (allow)
    );

    pmu_evt_sel #(.EV_N(EV_N)) u_sel (
        .sel_i       (st_q.ctl[CTL_SEL_LO +: SEL_W]),
        .common_ev_i (common_ev_i),
        .class_ev_i  (class_ev_i),
        .hit_o       (hit)
    );

    always_comb begin
        st_d = st_q;
        tick = allow && hit;
        if (wr_ctl_i) st_d.ctl = wdata_i[CTL_RW_W-1:0];
        if (wr_cnt_i)  st_d.cnt = wdata_i;
        else if (tick) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        ctl_o = '0;
        ctl_o[CTL_RW_W-1:0] = st_q.ctl;
        ctl_o[DATA_W-1]     = (IS_LAST == 0);
    end

    assign cnt_o = st_q.cnt;
    assign irq_o = st_q.cnt[DATA_W-1] && st_q.ctl[CTL_IE];

    // software write to the count beats a same-cycle event
    assert_write_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_cnt_i |=> (cnt_o == $past(wdata_i)));

    // one qualifying cycle adds exactly one, modulo the width
    assert_single_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_cnt_i && allow && hit) |=> (cnt_o == $past(cnt_o) + 1'b1));

    // no write and no qualifying event leaves the count alone
    assert_hold_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_cnt_i && !(allow && hit)) |=> $stable(cnt_o));

    // control write lands in the writable field
    assert_ctl_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_ctl_i |=> (ctl_o[CTL_RW_W-1:0] == $past(wdata_i[CTL_RW_W-1:0])));
endmodule

// File: rtl/perf_mon_unit.sv
`timescale 1ns/1ps
module perf_mon_unit
    import pmu_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    parameter int DATA_W    = 32,
    parameter int EV_N      = 8,
    localparam int IDX_W    = $clog2(NUM_PAIRS),
    localparam int ADDR_W   = IDX_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [1:0]        ksu_i,
    input  logic              exl_i,
    input  logic              erl_i,
    input  logic [1:0]        common_ev_i,
    input  logic [EV_N-1:0]   even_ev_i,
    input  logic [EV_N-1:0]   odd_ev_i,
    output logic              irq_o,
    output logic [DATA_W-1:0] cfg_word_o,
    output logic [DATA_W-1:0] cause_word_o
);
    logic [DATA_W-1:0]    ctl_arr [NUM_PAIRS];
    logic [DATA_W-1:0]    cnt_arr [NUM_PAIRS];
    logic [NUM_PAIRS-1:0] irq_vec;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        logic [EV_N-1:0] cls_ev;
        logic            hit_ctl;
        logic            hit_cnt;

        assign cls_ev  = ((p % 2) == 1) ? odd_ev_i : even_ev_i;
        assign hit_ctl = wr_en_i && (addr_i == ADDR_W'(2 * p));
        assign hit_cnt = wr_en_i && (addr_i == ADDR_W'(2 * p + 1));

        pmu_pair #(
            .DATA_W  (DATA_W),
            .EV_N    (EV_N),
            .IS_LAST ((p == NUM_PAIRS - 1) ? 1 : 0)
        ) u_pair (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .wr_ctl_i    (hit_ctl),
            .wr_cnt_i    (hit_cnt),
            .wdata_i     (wdata_i),
            .ksu_i       (ksu_i),
            .exl_i       (exl_i),
            .erl_i       (erl_i),
            .common_ev_i (common_ev_i),
            .class_ev_i  (cls_ev),
            .ctl_o       (ctl_arr[p]),
            .cnt_o       (cnt_arr[p]),
            .irq_o       (irq_vec[p])
        );
    end

    always_comb begin
        rdata_o = '0;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            if (addr_i[ADDR_W-1:1] == IDX_W'(p))
                rdata_o = addr_i[0] ? cnt_arr[p] : ctl_arr[p];
        end
    end

    assign irq_o = |irq_vec;

    always_comb begin
        cfg_word_o = '0;
        cfg_word_o[CFG_PRESENT_BIT] = 1'b1;
        cause_word_o = '0;
        cause_word_o[CAUSE_PEND_BIT] = irq_o;
    end

    // a pending interrupt with no register write can only drop by a count wrapping
    assert_irq_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !wr_en_i && (common_ev_i == 2'b00) && (even_ev_i == '0) && (odd_ev_i == '0))
        |=> irq_o);
endmodule

// File: tb/perf_mon_unit_tb.sv
`timescale 1ns/1ps
module perf_mon_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  ksu = 2'b00;
    logic        exl = 1'b0;
    logic        erl = 1'b0;
    logic [1:0]  cev = '0;
    logic [7:0]  eev = '0;
    logic [7:0]  oev = '0;
    logic        irq;
    logic [31:0] cfg_w;
    logic [31:0] cause_w;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    perf_mon_unit dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .wr_en_i      (wr_en),
        .addr_i       (addr),
        .wdata_i      (wdata),
        .rdata_o      (rdata),
        .ksu_i        (ksu),
        .exl_i        (exl),
        .erl_i        (erl),
        .common_ev_i  (cev),
        .even_ev_i    (eev),
        .odd_ev_i     (oev),
        .irq_o        (irq),
        .cfg_word_o   (cfg_w),
        .cause_word_o (cause_w)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input int a, input logic [31:0] d);
        wr_en = 1'b1; addr = 3'(a); wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        addr = 3'(a);
        #1 d = rdata;
    endtask

    task automatic run(input logic [1:0] c, input logic [7:0] e, input logic [7:0] o, input int n);
        cev = c; eev = e; oev = o;
        repeat (n) @(posedge clk);
        @(negedge clk);
        cev = '0; eev = '0; oev = '0;
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 4; i++) begin
            rd_chk("R1/R2 control after reset", 2 * i, (i < 3) ? 32'h8000_0000 : 32'h0);
            rd_chk("R1/R11 count after reset", 2 * i + 1, 32'h0);
        end
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        chk("R3 config word", cfg_w, 32'h0000_0010);
        chk("R9 cause word idle", cause_w, 32'h0);
    endtask

    task automatic t_ctl_field;
        wr(2, 32'hFFFF_FFFF);
        rd_chk("R2 field mask slot1", 2, 32'h8000_7FFF);
        wr(6, 32'hFFFF_FFFF);
        rd_chk("R2 last slot more flag clear", 6, 32'h0000_7FFF);
        wr(2, 32'h0);
        wr(6, 32'h0);
        rd_chk("R11 control write reaches slot1 only", 2, 32'h8000_0000);
    endtask

    task automatic t_modes;
        wr(0, 32'h2);                          // kernel enable, selector 0
        run(2'b01, '0, '0, 3);
        rd_chk("R4 kernel counts in ksu 00", 1, 32'd3);
        ksu = 2'b10; run(2'b01, '0, '0, 4);
        rd_chk("R4 kernel blocked in user", 1, 32'd3);
        erl = 1'b1; run(2'b01, '0, '0, 2); erl = 1'b0;
        rd_chk("R4 kernel via erl", 1, 32'd5);
        exl = 1'b1; run(2'b01, '0, '0, 2); exl = 1'b0;
        rd_chk("R4 kernel via exl", 1, 32'd7);
        wr(0, 32'h8);                          // user only
        run(2'b01, '0, '0, 3);
        rd_chk("R4 user counts", 1, 32'd10);
        exl = 1'b1; run(2'b01, '0, '0, 2); exl = 1'b0;
        rd_chk("R4 user blocked by exl", 1, 32'd10);
        ksu = 2'b01; run(2'b01, '0, '0, 2);
        rd_chk("R4 user blocked in supervisor", 1, 32'd10);
        wr(0, 32'h4);
        run(2'b01, '0, '0, 2);
        rd_chk("R4 supervisor counts", 1, 32'd12);
        wr(0, 32'h1); ksu = 2'b10;
        run(2'b01, '0, '0, 2);
        rd_chk("R4 exl enable idle without exl", 1, 32'd12);
        exl = 1'b1; run(2'b01, '0, '0, 3); exl = 1'b0;
        rd_chk("R4 exl enable counts", 1, 32'd15);
        ksu = 2'b00;
    endtask

    task automatic t_pause;
        wr(0, 32'hF);
        run(2'b01, '0, '0, 4);
        rd_chk("R5 running", 1, 32'd19);
        wr(0, 32'h0);
        run(2'b11, 8'hFF, 8'hFF, 5);
        rd_chk("R5 paused holds", 1, 32'd19);
        wr(0, 32'hF);
        run(2'b01, '0, '0, 2);
        rd_chk("R5 resume from held value", 1, 32'd21);
    endtask

    task automatic t_select;
        wr(1, 32'h0); wr(3, 32'h0);
        wr(0, 32'h42); wr(2, 32'h42);          // selector 2, kernel
        run(2'b00, 8'h01, 8'h00, 3);
        rd_chk("R6 even source on even slot", 1, 32'd3);
        rd_chk("R6 even source ignored by odd slot", 3, 32'd0);
        run(2'b00, 8'h00, 8'h01, 2);
        rd_chk("R6 odd source ignored by even slot", 1, 32'd3);
        rd_chk("R6 odd source on odd slot", 3, 32'd2);
        wr(0, 32'h22); wr(2, 32'h22);          // selector 1 both
        run(2'b10, '0, '0, 4);
        rd_chk("R6 shared instr even", 1, 32'd7);
        rd_chk("R6 shared instr odd", 3, 32'd6);
        wr(0, 32'h122);                        // selector 9 -> even_ev[7]
        run(2'b00, 8'h80, 8'h00, 2);
        rd_chk("R6 highest selector", 1, 32'd9);
        wr(0, 32'h142);                        // selector 10 -> none
        run(2'b11, 8'hFF, 8'hFF, 3);
        rd_chk("R6 out of range selector", 1, 32'd9);
        rd_chk("R6 odd shared alongside", 3, 32'd9);
        wr(0, 32'h0); wr(2, 32'h0);
    endtask

    task automatic t_overflow;
        wr(4, 32'h12);
        wr(5, 32'h7FFF_FFFE);
        run(2'b01, '0, '0, 1);
        rd_chk("R7 below top bit", 5, 32'h7FFF_FFFF);
        chk("R8 no irq below top bit", {31'b0, irq}, 32'h0);
        run(2'b01, '0, '0, 1);
        rd_chk("R7 reaches top bit", 5, 32'h8000_0000);
        chk("R8 irq on top bit", {31'b0, irq}, 32'h1);
        chk("R9 cause pending", cause_w, 32'h0400_0000);
        wr(4, 32'h02);
        chk("R8 irq masked by enable", {31'b0, irq}, 32'h0);
        wr(4, 32'h12);
        chk("R8 irq back with enable", {31'b0, irq}, 32'h1);
        wr(5, 32'h5);
        chk("R10 write clears overflow", {31'b0, irq}, 32'h0);
        chk("R9 cause cleared", cause_w, 32'h0);
        wr(4, 32'h0);
        wr(7, 32'hFFFF_FFFF); wr(6, 32'h02);
        run(2'b01, '0, '0, 1);
        rd_chk("R7 wraps to zero", 7, 32'h0);
        wr(6, 32'h0);
    endtask

    task automatic t_collision;
        wr(0, 32'h2);
        cev = 2'b01;
        wr(1, 32'h100);
        cev = 2'b00;
        rd_chk("R10 write beats same-cycle event", 1, 32'h100);
        run(2'b01, '0, '0, 1);
        rd_chk("R10 counting continues after write", 1, 32'h101);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired R1 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctl_field();
        t_modes();
        t_pause();
        t_select();
        t_overflow();
        t_collision();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule